// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the programming state for a parameterised set of hardware debug triggers and exposes it through a register-access port. Software reaches every trigger through one window. An index register chooses the trigger. A packed control word and a compare value are then read and written for that trigger. A fourth, auxiliary address is always zero. The block does not compare addresses and does not start debug entry. It reports to the fetch, load and store paths whether any trigger is armed for them, so that each path can skip matching when no trigger watches it.

Each request is decoded into one access kind: ACC_NONE, ACC_SEL, ACC_CTL, ACC_CMP or ACC_AUX. A `unique case` on that kind selects the read data. The read data and the illegal flag are combinational. They are valid in the cycle the request is presented. A write takes effect at the next rising clock edge. A control word whose debug-owner bit is set is locked, and a write to it made outside debug mode is rejected.

Top module: `trig_csr_bank`

## Requirements
- R1: After reset the index register reads 0, every compare value reads 0, and every control word reads 0x2000_0000 (kind field = 2, all other fields 0). All three path enables are 0.
- R2: A write to the index register is accepted only when the full written value is below NUM_TRIG. Any other value leaves the index unchanged.
- R3: Control word layout, with XLEN = 32:
  - kind at [31:28]: always reads 2.
  - owner bit at [27].
  - mask limit at [26:21]: always reads MASKMAX_VAL, which is 0 by default.
  - bit [20]: reads 0.
  - data-select at [19], timing at [18], action at [17:12], chain at [11], match at [10:7].
  - privilege enables m, h, s, u at [6], [5], [4], [3].
  - execute at [2], store at [1], load at [0].
  - An accepted write stores every field from the data except kind and mask limit.
- R4: A control-word write to the selected trigger is rejected when its stored owner bit is 1 and the debug-mode input is 0. In that cycle `rsp_illegal` is 1 and `rsp_rdata` is 0, and no state changes.
- R5: On an accepted control write the timing bit is forced to 0 when execute is 1. It is then forced to 1 when load is 1, so load wins. When neither is set, the written timing value is kept.
- R6: Each trigger has its own compare register. Reads and writes at the compare address reach the trigger chosen by the index register.
- R7: The auxiliary address and any unmapped address read 0. Writes to them change nothing.
- R8: `fetch_chk_en`, `load_chk_en` and `store_chk_en` are the OR over all triggers of the stored execute, load and store bits. They follow a control write from the next cycle on.
- R9: `rsp_illegal` is 0 for reads, for writes to other addresses, and for control writes to an unlocked trigger or made in debug mode. For any request that is not rejected, `rsp_rdata` returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | XLEN | Write data |
| req_dbg | input | 1 | Requester is in debug mode |
| rsp_rdata | output | XLEN | Read data, same cycle |
| rsp_illegal | output | 1 | Request rejected as an illegal access |
| fetch_chk_en | output | 1 | Some trigger watches instruction fetch |
| load_chk_en | output | 1 | Some trigger watches loads |
| store_chk_en | output | 1 | Some trigger watches stores |

## Verification
The hardest situation to reach from the ports is a locked trigger that then receives a control write outside debug mode. The stimulus first selects the trigger. It then writes a control word with the owner bit set while the debug input is high. Only after that does it drop the debug input and attempt the write. Immediate read-backs show that nothing moved, and a later write in debug mode unlocks the trigger. The timing override is reached by writing the same index with execute only, with load only, with both, and with neither, and by setting the incoming timing bit to the opposite of the forced value each time.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_CTL,
        ACC_CMP,
        ACC_AUX
    } acc_kind_e;

    // Low part of a trigger control word: fields in bit order [19:0]
    typedef struct packed {
        logic       dmode;
        logic       sel_data;
        logic       timing;
        logic [5:0] action;
        logic       chain;
        logic [3:0] match_kind;
        logic       priv_m;
        logic       priv_h;
        logic       priv_s;
        logic       priv_u;
        logic       on_exec;
        logic       on_store;
        logic       on_load;
    } trig_ctl_t;

    localparam int unsigned LOW_W          = 20;
    localparam logic [3:0]  TRIG_KIND_ADDR = 4'd2;

    function automatic trig_ctl_t ctl_from_word(input logic dm, input logic [LOW_W-1:0] low);
        trig_ctl_t c;
        c.dmode      = dm;
        c.sel_data   = low[19];
        c.timing     = low[18];
        c.action     = low[17:12];
        c.chain      = low[11];
        c.match_kind = low[10:7];
        c.priv_m     = low[6];
        c.priv_h     = low[5];
        c.priv_s     = low[4];
        c.priv_u     = low[3];
        c.on_exec    = low[2];
        c.on_store   = low[1];
        c.on_load    = low[0];
        // access-type override: load has the last word
        if (c.on_exec) c.timing = 1'b0;
        if (c.on_load) c.timing = 1'b1;
        return c;
    endfunction

    function automatic logic [LOW_W-1:0] ctl_low(input trig_ctl_t c);
        return {c.sel_data, c.timing, c.action, c.chain, c.match_kind,
                c.priv_m, c.priv_h, c.priv_s, c.priv_u,
                c.on_exec, c.on_store, c.on_load};
    endfunction

endpackage

// File: rtl/trig_csr_decode.sv
module trig_csr_decode
    import trig_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h7A0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h7A1,
    parameter logic [ADDR_W-1:0] CMP_ADDR = 12'h7A2,
    parameter logic [ADDR_W-1:0] AUX_ADDR = 12'h7A3
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_kind_e         kind
);
    always_comb begin
        kind = ACC_NONE;
        if (req_valid) begin
            if (req_addr == SEL_ADDR)      kind = ACC_SEL;
            else if (req_addr == CTL_ADDR) kind = ACC_CTL;
            else if (req_addr == CMP_ADDR) kind = ACC_CMP;
            else if (req_addr == AUX_ADDR) kind = ACC_AUX;
        end
    end
endmodule

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wdata,
    output logic [SEL_W-1:0] sel_q
);
    logic accept;

    // full-width compare: wide values must not alias into range
    always_comb begin
        accept = wr_en && (wdata < XLEN'(NUM_TRIG));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (accept) sel_q <= wdata[SEL_W-1:0];
    end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
    import trig_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             cmp_wr,
    input  logic             wr_dmode,
    input  logic [LOW_W-1:0] wr_low,
    input  logic [XLEN-1:0]  wr_data,
    output trig_ctl_t        ctl_q,
    output logic [XLEN-1:0]  cmp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cmp_q <= '0;
        end else begin
            if (ctl_wr) ctl_q <= ctl_from_word(wr_dmode, wr_low);
            if (cmp_wr) cmp_q <= wr_data;
        end
    end
endmodule

// File: rtl/trig_path_or.sv
module trig_path_or #(
    parameter int unsigned NUM_TRIG = 4
) (
    input  logic [NUM_TRIG-1:0] exec_bits,
    input  logic [NUM_TRIG-1:0] load_bits,
    input  logic [NUM_TRIG-1:0] store_bits,
    output logic                fetch_en,
    output logic                load_en,
    output logic                store_en
);
    always_comb begin
        fetch_en = |exec_bits;
        load_en  = |load_bits;
        store_en = |store_bits;
    end
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
    import trig_pkg::*;
#(
    parameter int unsigned       XLEN        = 32,
    parameter int unsigned       NUM_TRIG    = 4,
    parameter int unsigned       ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 12'h7A0,
    parameter logic [ADDR_W-1:0] CTL_ADDR    = 12'h7A1,
    parameter logic [ADDR_W-1:0] CMP_ADDR    = 12'h7A2,
    parameter logic [ADDR_W-1:0] AUX_ADDR    = 12'h7A3,
    parameter logic [5:0]        MASKMAX_VAL = 6'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic              req_dbg,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal,
    output logic              fetch_chk_en,
    output logic              load_chk_en,
    output logic              store_chk_en
);
    localparam int unsigned SEL_W     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
    localparam int unsigned KIND_LSB  = XLEN - 4;
    localparam int unsigned DMODE_BIT = XLEN - 5;
    localparam int unsigned MASK_LSB  = XLEN - 11;

    acc_kind_e           kind;
    logic [SEL_W-1:0]    sel_q;
    trig_ctl_t           ctl_q [NUM_TRIG];
    logic [XLEN-1:0]     cmp_q [NUM_TRIG];
    logic [NUM_TRIG-1:0] exec_bits;
    logic [NUM_TRIG-1:0] load_bits;
    logic [NUM_TRIG-1:0] store_bits;
    logic [NUM_TRIG-1:0] timing_bits;

    trig_ctl_t           cur_ctl;
    logic [XLEN-1:0]     cur_cmp;
    logic                cur_hit;
    logic                locked_wr;
    logic                sel_wr;
    logic                ctl_wr_ok;
    logic                cmp_wr_ok;
    logic [XLEN-1:0]     ctl_word;

    trig_csr_decode #(
        .ADDR_W  (ADDR_W),
        .SEL_ADDR(SEL_ADDR),
        .CTL_ADDR(CTL_ADDR),
        .CMP_ADDR(CMP_ADDR),
        .AUX_ADDR(AUX_ADDR)
    ) u_dec (
        .req_valid(req_valid),
        .req_addr (req_addr),
        .kind     (kind)
    );

    // selected trigger view; an index with no slot yields zeros
    always_comb begin
        cur_ctl = '0;
        cur_cmp = '0;
        cur_hit = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (sel_q == SEL_W'(i)) begin
                cur_ctl = ctl_q[i];
                cur_cmp = cmp_q[i];
                cur_hit = 1'b1;
            end
        end
    end

    always_comb begin
        locked_wr = req_write && (kind == ACC_CTL) && cur_ctl.dmode && !req_dbg;
        sel_wr    = req_write && (kind == ACC_SEL);
        ctl_wr_ok = req_write && (kind == ACC_CTL) && !locked_wr;
        cmp_wr_ok = req_write && (kind == ACC_CMP);
    end

    always_comb begin
        ctl_word = '0;
        if (cur_hit) begin
            ctl_word[XLEN-1:KIND_LSB]       = TRIG_KIND_ADDR;
            ctl_word[DMODE_BIT]             = cur_ctl.dmode;
            ctl_word[MASK_LSB+5:MASK_LSB]   = MASKMAX_VAL;
            ctl_word[LOW_W-1:0]             = ctl_low(cur_ctl);
        end
    end

    trig_sel_reg #(
        .XLEN    (XLEN),
        .NUM_TRIG(NUM_TRIG),
        .SEL_W   (SEL_W)
    ) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(sel_wr),
        .wdata(req_wdata),
        .sel_q(sel_q)
    );

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        logic hit_g;
        assign hit_g = (sel_q == SEL_W'(g));

        trig_slot #(.XLEN(XLEN)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (ctl_wr_ok && hit_g),
            .cmp_wr  (cmp_wr_ok && hit_g),
            .wr_dmode(req_wdata[DMODE_BIT]),
            .wr_low  (req_wdata[LOW_W-1:0]),
            .wr_data (req_wdata),
            .ctl_q   (ctl_q[g]),
            .cmp_q   (cmp_q[g])
        );

        assign exec_bits[g]   = ctl_q[g].on_exec;
        assign load_bits[g]   = ctl_q[g].on_load;
        assign store_bits[g]  = ctl_q[g].on_store;
        assign timing_bits[g] = ctl_q[g].timing;
    end

    trig_path_or #(.NUM_TRIG(NUM_TRIG)) u_or (
        .exec_bits (exec_bits),
        .load_bits (load_bits),
        .store_bits(store_bits),
        .fetch_en  (fetch_chk_en),
        .load_en   (load_chk_en),
        .store_en  (store_chk_en)
    );

    // output process: read data by access kind
    always_comb begin
        rsp_illegal = locked_wr;
        rsp_rdata   = '0;
        if (!locked_wr) begin
            unique case (kind)
                ACC_SEL:  rsp_rdata = XLEN'(sel_q);
                ACC_CTL:  rsp_rdata = ctl_word;
                ACC_CMP:  rsp_rdata = cur_cmp;
                ACC_AUX:  rsp_rdata = '0;
                ACC_NONE: rsp_rdata = '0;
                default:  rsp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/trig_csr_bank_chk.sv
module trig_csr_bank_chk #(
    parameter int unsigned       XLEN     = 32,
    parameter int unsigned       NUM_TRIG = 4,
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       SEL_W    = 2,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h7A0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h7A1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [XLEN-1:0]     req_wdata,
    input logic                req_dbg,
    input logic                rsp_illegal,
    input logic                fetch_chk_en,
    input logic [SEL_W-1:0]    sel_q,
    input logic [NUM_TRIG-1:0] exec_bits,
    input logic [NUM_TRIG-1:0] load_bits,
    input logic [NUM_TRIG-1:0] store_bits,
    input logic [NUM_TRIG-1:0] timing_bits
);
    assert_sel_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < int'(NUM_TRIG));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == SEL_ADDR && req_wdata >= XLEN'(NUM_TRIG))
        |=> $stable(sel_q));

    assert_illegal_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (req_valid && req_write && req_addr == CTL_ADDR && !req_dbg));

    assert_locked_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |=> ($stable(exec_bits) && $stable(load_bits)
                         && $stable(store_bits) && $stable(timing_bits)));

    assert_fetch_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_chk_en) |-> $past(req_valid && req_write && req_addr == CTL_ADDR));

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_tim
        assert_load_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
            load_bits[g] |-> timing_bits[g]);
        assert_exec_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_bits[g] && !load_bits[g]) |-> !timing_bits[g]);
    end
endmodule

bind trig_csr_bank trig_csr_bank_chk #(
    .XLEN    (XLEN),
    .NUM_TRIG(NUM_TRIG),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .SEL_ADDR(SEL_ADDR),
    .CTL_ADDR(CTL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_dbg     (req_dbg),
    .rsp_illegal (rsp_illegal),
    .fetch_chk_en(fetch_chk_en),
    .sel_q       (sel_q),
    .exec_bits   (exec_bits),
    .load_bits   (load_bits),
    .store_bits  (store_bits),
    .timing_bits (timing_bits)
);

// File: tb/tb_trig_csr_bank.sv
`timescale 1ns/1ps
module tb_trig_csr_bank;
    localparam logic [11:0] A_SEL = 12'h7A0;
    localparam logic [11:0] A_CTL = 12'h7A1;
    localparam logic [11:0] A_CMP = 12'h7A2;
    localparam logic [11:0] A_AUX = 12'h7A3;
    localparam logic [11:0] A_BAD = 12'h345;
    localparam int          NT    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_dbg = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;
    logic        fetch_chk_en, load_chk_en, store_chk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_rd_q [$];
    bit          exp_il_q [$];
    string       exp_tag_q [$];

    int          m_sel;
    logic [31:0] m_ctl [NT];
    logic [31:0] m_cmp [NT];

    always #2.5 clk = ~clk;

    trig_csr_bank dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_dbg(req_dbg),
        .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
        .fetch_chk_en(fetch_chk_en), .load_chk_en(load_chk_en), .store_chk_en(store_chk_en)
    );

    function automatic logic [31:0] model_ctl(input logic [31:0] d);
        logic [31:0] w;
        w = (d & 32'h080F_FFFF) | 32'h2000_0000;
        if (d[2]) w[18] = 1'b0;
        if (d[0]) w[18] = 1'b1;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // monitor: pops expectations in the middle of the cycle
    always @(negedge clk) begin
        if (exp_rd_q.size() > 0) begin
            logic [31:0] er;
            bit          ei;
            string       et;
            er = exp_rd_q.pop_front();
            ei = exp_il_q.pop_front();
            et = exp_tag_q.pop_front();
            check({et, " rdata"}, rsp_rdata, er);
            check({et, " illegal"}, {31'd0, rsp_illegal}, {31'd0, ei});
        end
    end

    // driver: presents one request, predicts the response, updates the model
    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          input bit dbg, input string tag);
        logic [31:0] er;
        bit          il;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_dbg = dbg;
        il = wr && (a == A_CTL) && m_ctl[m_sel][27] && !dbg;
        if (il)              er = 32'd0;
        else if (a == A_SEL) er = 32'(m_sel);
        else if (a == A_CTL) er = m_ctl[m_sel];
        else if (a == A_CMP) er = m_cmp[m_sel];
        else                 er = 32'd0;
        exp_rd_q.push_back(er);
        exp_il_q.push_back(il);
        exp_tag_q.push_back(tag);
        if (wr && !il) begin
            if (a == A_SEL && d < 32'(NT)) m_sel = int'(d);
            if (a == A_CTL) m_ctl[m_sel] = model_ctl(d);
            if (a == A_CMP) m_cmp[m_sel] = d;
        end
        @(negedge clk);
    endtask

    task automatic check_en(input string tag);
        bit ef, el, es;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        ef = 0; el = 0; es = 0;
        for (int i = 0; i < NT; i++) begin
            ef |= m_ctl[i][2];
            el |= m_ctl[i][0];
            es |= m_ctl[i][1];
        end
        @(negedge clk);
        check({tag, " fetch_en"}, {31'd0, fetch_chk_en}, {31'd0, ef});
        check({tag, " load_en"},  {31'd0, load_chk_en},  {31'd0, el});
        check({tag, " store_en"}, {31'd0, store_chk_en}, {31'd0, es});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_sel = 0;
        for (int i = 0; i < NT; i++) begin
            m_ctl[i] = 32'h2000_0000;
            m_cmp[i] = 32'd0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset view
        access(0, A_SEL, 0, 0, "R1 reset index");
        access(0, A_CTL, 0, 0, "R1 reset control");
        access(0, A_CMP, 0, 0, "R1 reset compare");
        check_en("R1 reset enables");

        // R2 index acceptance
        access(1, A_SEL, 32'd2, 0, "R2 write index 2");
        access(0, A_SEL, 0, 0, "R2 read index 2");
        access(1, A_SEL, 32'd4, 0, "R2 write index 4 ignored");
        access(0, A_SEL, 0, 0, "R2 index kept after 4");
        access(1, A_SEL, 32'hFFFF_FFFF, 0, "R2 write huge ignored");
        access(1, A_SEL, 32'h0001_0001, 0, "R2 aliasing value ignored");
        access(0, A_SEL, 0, 0, "R2 index kept after huge");
        access(1, A_SEL, 32'd3, 0, "R2 write index 3");

        // R3 full write on trigger 3, in debug mode
        access(1, A_CTL, 32'hFFFF_FFFF, 1, "R3 write all ones");
        access(0, A_CTL, 0, 0, "R3 read fields");
        check_en("R8 all paths on");

        // R4 locked trigger
        access(1, A_CTL, 32'h0000_0000, 0, "R4 locked write rejected");
        access(0, A_CTL, 0, 0, "R4 state unchanged");
        access(1, A_CMP, 32'hCAFE_0003, 0, "R9 compare write on locked slot");
        access(0, A_CTL, 0, 1, "R9 read in debug mode");

        // R5 timing override, unlocked via debug write
        access(1, A_CTL, 32'h0004_0004, 1, "R5 exec clears timing");
        access(0, A_CTL, 0, 0, "R5 exec read");
        access(1, A_CTL, 32'h0004_0000, 0, "R5 plain timing kept");
        access(0, A_CTL, 0, 0, "R5 plain read");
        access(1, A_CTL, 32'h0000_0001, 0, "R5 load sets timing");
        access(0, A_CTL, 0, 0, "R5 load read");
        access(1, A_CTL, 32'h0000_0005, 0, "R5 load beats exec");
        access(0, A_CTL, 0, 0, "R5 both read");
        access(1, A_CTL, 32'h0000_0000, 0, "R9 unlocked write accepted");
        check_en("R8 all paths off");

        // R6 per-trigger compare
        access(1, A_SEL, 32'd0, 0, "R6 select 0");
        access(1, A_CMP, 32'hA5A5_0001, 0, "R6 write cmp 0");
        access(1, A_SEL, 32'd1, 0, "R6 select 1");
        access(1, A_CMP, 32'h1234_5678, 0, "R6 write cmp 1");
        access(0, A_CMP, 0, 0, "R6 read cmp 1");
        access(1, A_SEL, 32'd0, 0, "R6 reselect 0");
        access(0, A_CMP, 0, 0, "R6 read cmp 0");
        access(1, A_SEL, 32'd3, 0, "R6 select 3");
        access(0, A_CMP, 0, 0, "R6 read cmp 3");

        // R7 auxiliary and unmapped
        access(1, A_AUX, 32'hDEAD_BEEF, 0, "R7 aux write");
        access(0, A_AUX, 0, 0, "R7 aux read");
        access(1, A_BAD, 32'h0000_0007, 0, "R7 unmapped write");
        access(0, A_BAD, 0, 0, "R7 unmapped read");
        check_en("R7 no enables from unmapped write");

        // R8 per-path OR
        access(1, A_SEL, 32'd0, 0, "R8 select 0");
        access(1, A_CTL, 32'h0000_0002, 0, "R8 store only");
        check_en("R8 store path");
        access(1, A_SEL, 32'd2, 0, "R8 select 2");
        access(1, A_CTL, 32'h0000_0001, 0, "R8 load only");
        check_en("R8 store and load");
        access(1, A_SEL, 32'd1, 0, "R8 select 1");
        access(1, A_CTL, 32'h0000_0004, 0, "R8 exec only");
        check_en("R8 three paths");
        access(1, A_SEL, 32'd0, 0, "R8 select 0 again");
        access(1, A_CTL, 32'h0000_0000, 0, "R8 clear store");
        check_en("R8 store cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule